// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Line Error Flags

This block takes an asynchronous serial line, sampled on a baud-tick enable that pulses sixteen times per bit period, and turns it into characters. It finds a start bit, takes 5 to 8 data bits least-significant first, can check a parity bit, and checks the stop bit. Each character leaves on a valid/ready stream as an 8-bit value. A configurable input inversion lets the block sit behind an inverting line driver.

Three line conditions are kept as sticky flags: a parity mismatch, a stop bit read as low, and a break, which means the line held low for longer than one whole frame. The host clears each flag by pulsing its clear input. A single line-status interrupt stays high while any of the three flags is set. The flags are meant for a status register owned by a neighbouring block. That neighbour also owns the character buffer and the baud divider.

Stream rules: `rx_valid` rises in the cycle after the stop bit is sampled. It stays high, with `rx_data` held, until a clock edge where `rx_ready` is high. The receiver cannot stall the line. If a new character completes while the previous one is still waiting, the new character replaces the old one and `rx_valid` stays high.

Top module: `serial_rx_core`

## Requirements
- R1: Data bits are taken least-significant bit first. `cfg_wlen` codes 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. Bits of `rx_data` above the word length read as 0.
- R2: A start is armed only after the line has been seen high. A falling level is taken as a start bit only if the line is still low at the sample 8 ticks later. Every later bit is sampled 16 ticks after the previous sample. A low pulse shorter than half a bit produces no character.
- R3: When `cfg_par_en`=1 and `cfg_par_stick`=0, with `cfg_par_even`=1 the data bits plus the parity bit must hold an even number of ones, and with `cfg_par_even`=0 an odd number. A mismatch sets `err_parity`.
- R4: When `cfg_par_en`=1 and `cfg_par_stick`=1, the parity bit must be 0 if `cfg_par_even`=1 and 1 if `cfg_par_even`=0. Any other value sets `err_parity`.
- R5: A stop bit sampled as 0 sets `err_frame`. The character is still delivered.
- R6: `err_break` sets when the line stays low for more than 16×(1 + data bits + parity bit + 1) consecutive ticks. A low period of that length or shorter does not set it.
- R7: Each error flag is sticky. Later good characters leave it set. A one-cycle pulse on its own clear input clears only that flag. If a set and a clear happen in the same cycle, the set wins.
- R8: `line_irq` is high while at least one of `err_parity`, `err_frame` or `err_break` is high, and low when all three are clear.
- R9: When `cfg_rx_inv`=1, the level on `rx_in` is inverted before sampling, so the idle line is low and a start bit is high.
- R10: `rx_valid` and `rx_data` hold until an edge where `rx_ready`=1, and `rx_valid` drops after that edge. A character completed while the output is unaccepted overwrites `rx_data`.
- R11: After reset, `rx_valid`, all three error flags and `line_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Enable pulse, 16 per bit period |
| rx_in | input | 1 | Serial receive line |
| cfg_wlen | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| cfg_par_en | input | 1 | A parity bit follows the data |
| cfg_par_even | input | 1 | Even parity (or stick value 0) |
| cfg_par_stick | input | 1 | Fixed-value parity |
| cfg_rx_inv | input | 1 | Invert the line before sampling |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | Character available |
| rx_ready | input | 1 | Consumer accepts the character |
| clr_parity | input | 1 | Write-1 clear of err_parity |
| clr_frame | input | 1 | Write-1 clear of err_frame |
| clr_break | input | 1 | Write-1 clear of err_break |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_break | output | 1 | Sticky break condition |
| line_irq | output | 1 | Any line error flag set |

## Verification
Assertions check several rules on every cycle: flags stay set without a clear, an accepted output drops, a rejected start returns to idle, upper bits are zero for short words, and a break flag can only rise while the line is low. The bench's scenarios are needed for what depends on a whole frame: the exact parity rules under each mode, the data value assembled from serial bits, inversion, the break threshold on both sides of the frame length, and overwrite of an unaccepted character.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic logic [3:0] data_bits(input logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic invert,
  output logic line
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b11;
    else        stage <= {stage[0], rx_in ^ invert};
  end

  assign line = stage[1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [3:0]        nbits,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              done,
  output logic [DATA_W-1:0] char_out,
  output logic              par_bad,
  output logic              stop_bad
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              dpar;
  logic              pbit;
  logic              armed;
  logic              last_bit;

  assign last_bit = (idx == IDX_W'(nbits - 4'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      dpar     <= 1'b0;
      pbit     <= 1'b0;
      armed    <= 1'b0;
      done     <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (line) armed <= 1'b1;
          if (tick && !line && armed) begin
            state <= ST_START;
            cnt   <= '0;
            armed <= 1'b0;
          end
        end
        ST_START: if (tick) begin
          if (cnt == MID) begin
            cnt <= '0;
            if (!line) begin
              state <= ST_DATA;
              idx   <= '0;
              dpar  <= 1'b0;
              shreg <= '0;
            end else begin
              state <= ST_IDLE;
              armed <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: if (tick) begin
          if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {line, shreg[DATA_W-1:1]};
            dpar  <= dpar ^ line;
            idx   <= idx + 1'b1;
            if (last_bit) state <= par_en ? ST_PAR : ST_STOP;
          end else cnt <= cnt + 1'b1;
        end
        ST_PAR: if (tick) begin
          if (cnt == LAST) begin
            cnt   <= '0;
            pbit  <= line;
            state <= ST_STOP;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP: if (tick) begin
          if (cnt == LAST) begin
            cnt      <= '0;
            done     <= 1'b1;
            stop_bad <= !line;
            armed    <= line;
            state    <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Right-align the received bits: the first bit ends up in bit 0.
  always_comb begin
    char_out = shreg >> (4'd8 - nbits);
    if (!par_en)        par_bad = 1'b0;
    else if (par_stick) par_bad = (pbit == par_even);
    else                par_bad = ((dpar ^ pbit) == par_even);
  end

  // R2: a start bit that is high again at mid-bit falls back to idle
  a_r2_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && tick && cnt == MID && line) |=> (state == ST_IDLE));

  // R1: five-bit words never carry bits above the word length
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nbits == 4'd5) |-> (char_out[7:5] == 3'b000));
endmodule

// File: rtl/rx_break_det.sv
module rx_break_det #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [3:0] nbits,
  input  logic       par_en,
  output logic       brk_hit
);
  localparam int BW = $clog2(OVS * 12 + 2);

  logic [BW-1:0] low_cnt;
  logic [BW-1:0] limit;

  always_comb begin
    limit   = BW'(OVS) * BW'(4'd2 + nbits + {3'b000, par_en});
    brk_hit = tick && !line && (low_cnt == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_cnt <= '0;
    else if (line)            low_cnt <= '0;
    else if (tick && low_cnt <= limit) low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/rx_err_flags.sv
module rx_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_par,
  input  logic set_frm,
  input  logic set_brk,
  input  logic clr_par,
  input  logic clr_frm,
  input  logic clr_brk,
  output logic par_flag,
  output logic frm_flag,
  output logic brk_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_flag <= 1'b0;
      frm_flag <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      par_flag <= set_par | (par_flag & ~clr_par);
      frm_flag <= set_frm | (frm_flag & ~clr_frm);
      brk_flag <= set_brk | (brk_flag & ~clr_brk);
    end
  end

  // R7: flags hold without a clear
  a_r7_sticky_par: assert property (@(posedge clk) disable iff (!rst_n)
    (par_flag && !clr_par) |=> par_flag);
  a_r7_sticky_frm: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_flag && !clr_frm) |=> frm_flag);
  a_r7_sticky_brk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !clr_brk) |=> brk_flag);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_in,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_rx_inv,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              clr_parity,
  input  logic              clr_frame,
  input  logic              clr_break,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_break,
  output logic              line_irq
);
  logic              line_s;
  logic [3:0]        nbits;
  logic              done;
  logic [DATA_W-1:0] char_w;
  logic              par_bad;
  logic              stop_bad;
  logic              brk_hit;

  assign nbits = data_bits(cfg_wlen);

  rx_line_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_in  (rx_in),
    .invert (cfg_rx_inv),
    .line   (line_s)
  );

  rx_frame_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .line      (line_s),
    .nbits     (nbits),
    .par_en    (cfg_par_en),
    .par_even  (cfg_par_even),
    .par_stick (cfg_par_stick),
    .done      (done),
    .char_out  (char_w),
    .par_bad   (par_bad),
    .stop_bad  (stop_bad)
  );

  rx_break_det #(.OVS(OVS)) u_brk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .line    (line_s),
    .nbits   (nbits),
    .par_en  (cfg_par_en),
    .brk_hit (brk_hit)
  );

  rx_err_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_par  (done & par_bad),
    .set_frm  (done & stop_bad),
    .set_brk  (brk_hit),
    .clr_par  (clr_parity),
    .clr_frm  (clr_frame),
    .clr_brk  (clr_break),
    .par_flag (err_parity),
    .frm_flag (err_frame),
    .brk_flag (err_break)
  );

  // Output holding stage: a new character always replaces the old one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (done) begin
      rx_valid <= 1'b1;
      rx_data  <= char_w;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  assign line_irq = err_parity | err_frame | err_break;

  // R10: an accepted character leaves unless another one lands
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !done) |=> !rx_valid);

  // R10: an unaccepted character holds its value
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !done) |=> (rx_valid && $stable(rx_data)));

  // R6: the break flag can only rise while the line is low
  a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_break) |-> !line_s);
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_stick = 1'b0;
  logic       cfg_rx_inv = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic       clr_parity = 1'b0;
  logic       clr_frame = 1'b0;
  logic       clr_break = 1'b0;
  logic       err_parity, err_frame, err_break, line_irq;

  int checks = 0;
  int fails = 0;
  int tick_div = 1;
  int tdiv_cnt = 0;
  int got_cnt = 0;
  logic [7:0] got_data = '0;

  always #5 clk = ~clk;

  serial_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_rx_inv(cfg_rx_inv),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .clr_parity(clr_parity), .clr_frame(clr_frame), .clr_break(clr_break),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
    .line_irq(line_irq)
  );

  always @(negedge clk) begin
    if (tdiv_cnt >= tick_div - 1) begin
      tdiv_cnt  <= 0;
      baud_tick <= 1'b1;
    end else begin
      tdiv_cnt  <= tdiv_cnt + 1;
      baud_tick <= 1'b0;
    end
    if (rx_valid && rx_ready) begin
      got_cnt  <= got_cnt + 1;
      got_data <= rx_data;
    end
  end

  typedef struct packed {
    logic [1:0] wl;
    logic       pen;
    logic       ev;
    logic       st;
    logic       inv;
    logic [7:0] d;
    logic       pb;
    logic       sb;
    logic [7:0] ed;
    logic       epe;
    logic       efe;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0}, // R1
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0}, // R3 even ok
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0}, // R3 even bad
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h07, 1'b0, 1'b1, 8'h07, 1'b0, 1'b0}, // R3 odd ok
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h07, 1'b1, 1'b1, 8'h07, 1'b1, 1'b0}, // R3 odd bad
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF6, 1'b0, 1'b1, 8'h16, 1'b0, 1'b0}, // R1 5 bits
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hEB, 1'b0, 1'b1, 8'h2B, 1'b0, 1'b0}, // R1 6 bits
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0}, // R1 7 bits
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0}, // R4 stick 0 ok
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h01, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0}, // R4 stick 0 bad
    '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0}, // R4 stick 1 ok
    '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0}, // R4 stick 1 bad
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1}, // R5
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h96, 1'b0, 1'b1, 8'h96, 1'b0, 1'b0}, // R9
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h96, 1'b1, 1'b1, 8'h96, 1'b1, 1'b0}  // R9 + R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bits(input int ticks);
    repeat (ticks * tick_div) @(negedge clk);
  endtask

  task automatic drive(input logic lvl);
    rx_in = lvl ^ cfg_rx_inv;
  endtask

  task automatic send_frame(input int nb, input logic [7:0] d, input logic pen,
                            input logic pb, input logic sb);
    @(negedge clk);
    drive(1'b0);
    hold_bits(16);
    for (int i = 0; i < nb; i++) begin
      drive(d[i]);
      hold_bits(16);
    end
    if (pen) begin
      drive(pb);
      hold_bits(16);
    end
    drive(sb);
    hold_bits(16);
    drive(1'b1);
    hold_bits(32);
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_parity = 1'b1; clr_frame = 1'b1; clr_break = 1'b1;
    @(negedge clk);
    clr_parity = 1'b0; clr_frame = 1'b0; clr_break = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 valid", rx_valid, 0);
    check("R11 flags", {err_parity, err_frame, err_break}, 0);
    check("R11 irq", line_irq, 0);
    hold_bits(20);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cfg_wlen = VECS[v].wl; cfg_par_en = VECS[v].pen; cfg_par_even = VECS[v].ev;
      cfg_par_stick = VECS[v].st; cfg_rx_inv = VECS[v].inv;
      drive(1'b1);
      hold_bits(20);
      clear_all();
      c0 = got_cnt;
      send_frame(5 + int'(VECS[v].wl), VECS[v].d, VECS[v].pen, VECS[v].pb, VECS[v].sb);
      check($sformatf("R1 vec%0d count", v), got_cnt - c0, 1);
      check($sformatf("R1 R9 vec%0d data", v), got_data, VECS[v].ed);
      check($sformatf("R3 R4 vec%0d parity", v), err_parity, VECS[v].epe);
      check($sformatf("R5 vec%0d frame", v), err_frame, VECS[v].efe);
      check($sformatf("R8 vec%0d irq", v), line_irq, VECS[v].epe | VECS[v].efe);
    end

    // Back to plain 8N1
    @(negedge clk);
    cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_par_stick = 1'b0; cfg_rx_inv = 1'b0;
    drive(1'b1);
    hold_bits(20);
    clear_all();

    // R2: short low glitch is not a start bit
    c0 = got_cnt;
    drive(1'b0); hold_bits(4); drive(1'b1); hold_bits(40);
    check("R2 glitch no char", got_cnt - c0, 0);
    check("R2 glitch no frame err", err_frame, 0);

    // R6: low for 158 ticks, below the 160-tick frame
    drive(1'b0); hold_bits(158); drive(1'b1); hold_bits(40);
    check("R6 short low no break", err_break, 0);
    check("R5 short low frame err", err_frame, 1);
    clear_all();

    // R6: low for 165 ticks
    drive(1'b0); hold_bits(165); drive(1'b1); hold_bits(40);
    check("R6 long low break", err_break, 1);
    check("R8 irq with break", line_irq, 1);

    // R7: a good character leaves the flags set
    send_frame(8, 8'h42, 1'b0, 1'b0, 1'b1);
    check("R7 break sticky", err_break, 1);
    check("R7 frame sticky", err_frame, 1);

    // R7: clear only the break flag
    @(negedge clk); clr_break = 1'b1; @(negedge clk); clr_break = 1'b0; @(negedge clk);
    check("R7 break cleared", err_break, 0);
    check("R7 frame kept", err_frame, 1);
    check("R8 irq still high", line_irq, 1);
    @(negedge clk); clr_frame = 1'b1; @(negedge clk); clr_frame = 1'b0; @(negedge clk);
    check("R8 irq low when clear", line_irq, 0);

    // R6: 5 bits with parity -> 128-tick frame
    @(negedge clk); cfg_wlen = 2'd0; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    hold_bits(20);
    clear_all();
    drive(1'b0); hold_bits(135); drive(1'b1); hold_bits(40);
    check("R6 5E1 break", err_break, 1);
    clear_all();

    // R10: overwrite while not ready
    @(negedge clk); cfg_wlen = 2'd3; cfg_par_en = 1'b0; rx_ready = 1'b0;
    hold_bits(20);
    send_frame(8, 8'h11, 1'b0, 1'b0, 1'b1);
    check("R10 valid held", rx_valid, 1);
    check("R10 data held", rx_data, 8'h11);
    send_frame(8, 8'h22, 1'b0, 1'b0, 1'b1);
    check("R10 overwrite", rx_data, 8'h22);
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk);
    check("R10 drop after accept", rx_valid, 0);

    // R2: slower tick, bits timed by ticks not clocks
    tick_div = 3;
    hold_bits(10);
    c0 = got_cnt;
    send_frame(8, 8'h5A, 1'b0, 1'b0, 1'b1);
    check("R2 slow tick count", got_cnt - c0, 1);
    check("R2 slow tick data", got_data, 8'h5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule